// File: doc/BRIEF.md
# Wide-to-Narrow Register Port Bridge

This block sits between a processor-side register port of CPU_DW bits and a narrow control/status register bus of CSR_DW bits, where the ratio RATIO = CPU_DW / CSR_DW is a power of two. Each processor read or write is turned into a burst of exactly RATIO single-cycle strobes on the narrow bus. The strobes go to consecutive chunk addresses, from the lowest to the highest. On a read, the returned chunks are collected into one wide word. On a write, the wide word is cut into chunks, and each chunk is driven with its own strobe.

The narrow bus returns read data one cycle after the read strobe and holds zero when no read was strobed. A register behind the bus takes a snapshot when its lowest chunk is read and commits a write only when its highest chunk is written. The ascending strobe order lets wide registers be read and written atomically. The processor side uses a level request with a one-cycle acknowledge. Only one request is handled at a time.

Top module: `csr_width_bridge`

## Requirements
- R1: During and after synchronous reset, `csr_r_stb`, `csr_w_stb` and `cpu_ack` are all low.
- R2: An accepted request (`cpu_req` high while idle) produces exactly RATIO strobes on RATIO consecutive cycles, starting on the cycle after acceptance. This holds even when the register behind the bus is narrower than the processor word.
- R3: The strobe with chunk index i carries `csr_addr` = `cpu_addr` * RATIO + i. The indices run in ascending order from 0 to RATIO-1.
- R4: On a write, the i-th `csr_w_stb` carries bits [i*CSR_DW +: CSR_DW] of `cpu_wdata` on `csr_w_data`, so chunk 0 is the least significant.
- R5: On a read, `csr_r_data` is taken on the cycle after each `csr_r_stb`. Chunk i is placed in bits [i*CSR_DW +: CSR_DW] of `cpu_rdata`, which is valid while `cpu_ack` is high.
- R6: `cpu_ack` is high for exactly one cycle, on the cycle right after the last strobe of the burst.
- R7: Changes to `cpu_req`, `cpu_we`, `cpu_addr` or `cpu_wdata` after a request has been accepted and before its acknowledge do not affect the strobes, addresses or write data of that burst.
- R8: `csr_r_stb` and `csr_w_stb` are never high in the same cycle. Both are low whenever no burst is in progress, including the acknowledge cycle.
- R9: `cpu_rdata` is zero in every cycle except the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held high until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | CPU_DW | Processor write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | CPU_DW | Assembled read data, valid with `cpu_ack` |
| csr_addr | output | CPU_AW+log2(RATIO) | Narrow bus chunk address |
| csr_r_stb | output | 1 | Narrow bus read strobe |
| csr_r_data | input | CSR_DW | Narrow bus read data, one cycle after strobe, zero otherwise |
| csr_w_stb | output | 1 | Narrow bus write strobe |
| csr_w_data | output | CSR_DW | Narrow bus write chunk |

## Verification
Reads and writes are drawn at random over the full address range, mixed with directed cases. The random mix covers all-ones and alternating-bit data, where a swapped or shifted chunk would show up, and the lowest and highest word addresses, where an address carry or truncation error would appear. A write whose top chunk is zero tells apart a bridge that skips zero or unused chunks from one that always issues the full burst. A burst during which the request inputs are scrambled separates latched request fields from ones read live. Read-after-write over a bench model of the bus checks that strobe timing and chunk placement match.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_kind_e;

    function automatic int ratio_shift(input int wide_w, input int narrow_w);
        return $clog2(wide_w / narrow_w);
    endfunction

    function automatic int index_width(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/bridge_sequencer.sv
module bridge_sequencer
    import csr_bridge_pkg::*;
#(
    parameter int RATIO = 4,
    parameter int IDX_W = 2,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             active,
    output op_kind_e         op,
    output logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    base_addr,
    output logic [DW-1:0]    wdata_hold,
    output logic             ack
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    op_kind_e         op_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            op_q    <= OP_READ;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= ST_BURST;
                        idx_q   <= '0;
                        op_q    <= we ? OP_WRITE : OP_READ;
                        addr_q  <= addr;
                        data_q  <= wdata;
                    end
                end
                ST_BURST: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign active     = (state_q == ST_BURST);
    assign ack        = (state_q == ST_DONE);
    assign op         = op_q;
    assign idx        = idx_q;
    assign base_addr  = addr_q;
    assign wdata_hold = data_q;

    // R2: acceptance starts a burst at chunk 0 on the next cycle
    a_r2_burst_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req) |=> (active && idx_q == '0));

    // R2/R3: chunk index advances by one per cycle inside the burst
    a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
        (active && idx_q != LAST_IDX) |=> (active && idx_q == $past(idx_q) + 1'b1));

    // R6: acknowledge follows the last chunk directly
    a_r6_ack_after_last: assert property (@(posedge clk) disable iff (rst)
        (active && idx_q == LAST_IDX) |=> ack);

    // R6: acknowledge lasts a single cycle
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R7: latched request fields do not move while the burst runs
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        active |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

endmodule

// File: rtl/chunk_slicer.sv
module chunk_slicer #(
    parameter int DW    = 32,
    parameter int CW    = 8,
    parameter int RATIO = 4,
    parameter int IDX_W = 2
) (
    input  logic [DW-1:0]    word,
    input  logic [IDX_W-1:0] sel,
    output logic [CW-1:0]    chunk
);
    logic [CW-1:0] pieces [RATIO];

    for (genvar g = 0; g < RATIO; g++) begin : g_piece
        assign pieces[g] = word[g*CW +: CW];
    end

    always_comb begin
        chunk = '0;
        for (int i = 0; i < RATIO; i++) begin
            if (sel == IDX_W'(i)) chunk = pieces[i];
        end
    end
endmodule

// File: rtl/read_gather.sv
module read_gather #(
    parameter int DW    = 32,
    parameter int CW    = 8,
    parameter int RATIO = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [CW-1:0]    bus_data,
    input  logic             present,
    output logic [DW-1:0]    word
);
    logic [CW-1:0] chunks [RATIO];

    for (genvar g = 0; g < RATIO; g++) begin : g_chunk
        if (g < RATIO - 1) begin : g_held
            logic [CW-1:0] hold_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                end else if (cap_en && cap_idx == IDX_W'(g)) begin
                    hold_q <= bus_data;
                end
            end
            assign chunks[g] = hold_q;
        end else begin : g_live
            assign chunks[g] = bus_data;
        end
    end

    always_comb begin
        word = '0;
        if (present) begin
            for (int i = 0; i < RATIO; i++) begin
                word[i*CW +: CW] = chunks[i];
            end
        end
    end
endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge
    import csr_bridge_pkg::*;
#(
    parameter int CPU_DW = 32,
    parameter int CSR_DW = 8,
    parameter int CPU_AW = 8,
    localparam int RATIO  = CPU_DW / CSR_DW,
    localparam int SHIFT  = ratio_shift(CPU_DW, CSR_DW),
    localparam int IDX_W  = index_width(CPU_DW / CSR_DW),
    localparam int CSR_AW = CPU_AW + SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic [CSR_AW-1:0] csr_addr,
    output logic              csr_r_stb,
    input  logic [CSR_DW-1:0] csr_r_data,
    output logic              csr_w_stb,
    output logic [CSR_DW-1:0] csr_w_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

    logic              active;
    op_kind_e          op;
    logic [IDX_W-1:0]  idx;
    logic [CPU_AW-1:0] base_addr;
    logic [CPU_DW-1:0] wdata_hold;
    logic [CSR_DW-1:0] wr_chunk;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic              rd_present;

    bridge_sequencer #(
        .RATIO(RATIO), .IDX_W(IDX_W), .AW(CPU_AW), .DW(CPU_DW)
    ) seq_i (
        .clk(clk), .rst(rst),
        .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
        .active(active), .op(op), .idx(idx),
        .base_addr(base_addr), .wdata_hold(wdata_hold), .ack(cpu_ack)
    );

    chunk_slicer #(
        .DW(CPU_DW), .CW(CSR_DW), .RATIO(RATIO), .IDX_W(IDX_W)
    ) slice_i (
        .word(wdata_hold), .sel(idx), .chunk(wr_chunk)
    );

    // chunk idx-1 was strobed last cycle, so its data is on the bus now
    assign cap_en     = active && (op == OP_READ) && (idx != '0);
    assign cap_idx    = idx - 1'b1;
    assign rd_present = cpu_ack && (op == OP_READ);

    read_gather #(
        .DW(CPU_DW), .CW(CSR_DW), .RATIO(RATIO), .IDX_W(IDX_W)
    ) gather_i (
        .clk(clk), .rst(rst),
        .cap_en(cap_en), .cap_idx(cap_idx), .bus_data(csr_r_data),
        .present(rd_present), .word(cpu_rdata)
    );

    assign csr_addr   = (CSR_AW'(base_addr) << SHIFT) | CSR_AW'(idx);
    assign csr_r_stb  = active && (op == OP_READ);
    assign csr_w_stb  = active && (op == OP_WRITE);
    assign csr_w_data = csr_w_stb ? wr_chunk : '0;

    // R8: the two strobes are mutually exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(csr_r_stb && csr_w_stb));

    // R8: no strobe during the acknowledge cycle
    a_r8_quiet_on_ack: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> (!csr_r_stb && !csr_w_stb));

    // R3: chunk addresses ascend by one within a burst
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        ((csr_r_stb || csr_w_stb) && idx != LAST_IDX)
            |=> ((csr_r_stb || csr_w_stb) && csr_addr == $past(csr_addr) + 1'b1));

    // R9: read data only shows up together with an acknowledge
    a_r9_rdata_gated: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack |-> (cpu_rdata == '0));

endmodule

// File: tb/csr_width_bridge_tb_top.sv
module csr_width_bridge_tb_top;
    localparam int CPU_DW = 32;
    localparam int CSR_DW = 8;
    localparam int CPU_AW = 8;
    localparam int RATIO  = CPU_DW / CSR_DW;
    localparam int CSR_AW = CPU_AW + 2;
    localparam int DEPTH  = 1 << CSR_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [CPU_AW-1:0] cpu_addr = '0;
    logic [CPU_DW-1:0] cpu_wdata = '0;
    logic              cpu_ack;
    logic [CPU_DW-1:0] cpu_rdata;
    logic [CSR_AW-1:0] csr_addr;
    logic              csr_r_stb;
    logic [CSR_DW-1:0] csr_r_data;
    logic              csr_w_stb;
    logic [CSR_DW-1:0] csr_w_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    csr_width_bridge #(.CPU_DW(CPU_DW), .CSR_DW(CSR_DW), .CPU_AW(CPU_AW)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .csr_addr(csr_addr), .csr_r_stb(csr_r_stb), .csr_r_data(csr_r_data),
        .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data)
    );

    // bench model of the narrow bus: read data one cycle late, zero when idle
    logic [CSR_DW-1:0] mem [DEPTH];
    logic [CSR_DW-1:0] rd_q = '0;
    assign csr_r_data = rd_q;

    function automatic logic [CSR_DW-1:0] seed_byte(input int a);
        return CSR_DW'((a * 37 + 11) ^ (a >> 3));
    endfunction

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = seed_byte(a);
    end

    always @(posedge clk) begin
        rd_q <= csr_r_stb ? mem[csr_addr] : '0;
        if (csr_w_stb) mem[csr_addr] <= csr_w_data;
    end

    function automatic logic [CPU_DW-1:0] model_word(input logic [CPU_AW-1:0] wa);
        logic [CPU_DW-1:0] w;
        w = '0;
        for (int i = 0; i < RATIO; i++) w[i*CSR_DW +: CSR_DW] = mem[int'(wa) * RATIO + i];
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // one access; scramble=1 changes request inputs mid-burst (R7)
    task automatic access(input logic we, input logic [CPU_AW-1:0] wa,
                          input logic [CPU_DW-1:0] wd, input bit scramble);
        logic [CPU_DW-1:0] exp_rd;
        int n_stb;
        int n;
        exp_rd = model_word(wa);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = wa; cpu_wdata = wd;
        n_stb = 0;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (scramble) begin
                cpu_we = ~we; cpu_addr = ~wa; cpu_wdata = ~wd;
            end
            if (cpu_ack) break;
            if (n > 10) break;
            // R8: exclusive strobes; R9: no read data before acknowledge
            check("R8 strobe type", {csr_r_stb, csr_w_stb}, we ? 2'b01 : 2'b10);
            check("R9 rdata idle", cpu_rdata, '0);
            // R3: ascending chunk address
            check("R3 chunk addr", csr_addr, int'(wa) * RATIO + n_stb);
            // R4: chunk slice of write data
            if (we) check("R4 wdata chunk", csr_w_data, wd[n_stb*CSR_DW +: CSR_DW]);
            n_stb++;
        end
        // R2: exact burst length; R6: ack on the cycle after the last strobe
        check("R2 strobe count", n_stb, RATIO);
        check("R6 ack timing", n, RATIO + 1);
        check("R8 quiet on ack", {csr_r_stb, csr_w_stb}, 2'b00);
        if (!we) check("R5 read word", cpu_rdata, exp_rd);
        else     check("R9 rdata on write ack", cpu_rdata, '0);
        cpu_req = 1'b0;
        @(negedge clk);
        check("R6 ack one cycle", cpu_ack, 1'b0);
        if (we) check("R4 write landed", model_word(wa), wd);
    endtask

    initial begin
        process::self().srandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset strobes", {csr_r_stb, csr_w_stb, cpu_ack}, 3'b000);
        cpu_req = 1'b1;
        @(negedge clk);
        check("R1 req in reset ignored", {csr_r_stb, csr_w_stb}, 2'b00);
        cpu_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle quiet", {csr_r_stb, csr_w_stb, cpu_ack}, 3'b000);

        // directed corners
        access(1'b0, 8'h00, '0, 1'b0);
        access(1'b1, 8'hFF, 32'hFFFF_FFFF, 1'b0);
        access(1'b0, 8'hFF, '0, 1'b0);
        access(1'b1, 8'h10, 32'h00A5_5AC3, 1'b0);   // R2: top chunk zero, still 4 strobes
        access(1'b0, 8'h10, '0, 1'b0);
        access(1'b1, 8'h21, 32'hAAAA_5555, 1'b1);   // R7: inputs scrambled mid-burst
        access(1'b0, 8'h21, '0, 1'b1);
        access(1'b1, 8'h00, 32'h0102_0304, 1'b0);
        access(1'b0, 8'h00, '0, 1'b0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            access(1'($urandom), CPU_AW'($urandom), $urandom, ($urandom % 4) == 0);
        end

        // R8: idle after traffic
        repeat (2) @(negedge clk);
        check("R8 idle after traffic", {csr_r_stb, csr_w_stb, cpu_ack}, 3'b000);
        finish_run();
    end
endmodule